// File: doc/BRIEF.md
# Selectable Sample Output Formatter

This block sits behind a 12-bit data converter core. Each clock it may accept one sample in offset-binary form, where the most negative input is all zeros and the most positive input is all ones. It registers that sample in one of three encodings: unchanged offset binary, two's complement, or Gray code. A two-bit strap code picks the encoding by default. A register write can replace that choice, and a later write can hand control back to the strap.

The registered word and its valid flag go out through tri-state drivers. An output-enable input lets the outputs go to high impedance while the converter is powered down. A separate combinational decoder turns a Gray word back into binary. It works from the top bit down, so a receiver or the bench can undo the Gray encoding and compare round trips.

Top module: `sample_format_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the registered word is cleared to 0 and the valid flag to 0. With `out_en` high, both read as 0 after reset.
- R2: Format code 2'b00 selects offset binary, which passes the sample through unchanged, so 0x000 stays 0x000 and 0xFFF stays 0xFFF.
- R3: Format code 2'b01 selects two's complement. Only bit 11 of the sample is inverted, so 0x800 becomes 0x000, 0xFFF becomes 0x7FF and 0x000 becomes 0x800.
- R4: Format code 2'b10 selects Gray code. Output bit 11 equals sample bit 11. Every lower output bit i is sample bit i XOR sample bit i+1, so 0x800 becomes 0xC00 and 0x7FF becomes 0x400.
- R5: The reserved format code 2'b11, from either the strap or the register, falls back to offset binary.
- R6: A write (`cfg_wr` high) with `cfg_override` high makes `cfg_fmt` the active code, whatever `strap_fmt` says. A write with `cfg_override` low returns control to `strap_fmt`. Reset returns control to the strap.
- R7: A sample presented with `in_valid` high at a rising edge appears on `dout` after that edge, with `dout_valid` high for that one cycle.
- R8: Each registered word uses a single format. A register write at the same edge as a sample takes effect from the next sample on. A strap value present at an edge applies to the sample taken at that edge.
- R9: At an edge where `in_valid` is low, `dout` keeps its previous word and `dout_valid` goes low.
- R10: While `out_en` is low, `dout` and `dout_valid` are not driven (high impedance). Raising `out_en` again shows the held word.
- R11: `dec_bin_out` is the combinational Gray-to-binary decode of `dec_gray_in`. Bit 11 is copied, and each lower bit is its Gray bit XOR the decoded bit above it, so decoding the R4 encoding of any sample returns that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 12 | Offset-binary sample |
| strap_fmt | input | 2 | Strap format code |
| cfg_wr | input | 1 | Override register write strobe |
| cfg_override | input | 1 | Written override enable |
| cfg_fmt | input | 2 | Written format code |
| out_en | input | 1 | Output enable; low releases the outputs |
| dout | output | 12 | Formatted sample (tri-state) |
| dout_valid | output | 1 | Valid flag (tri-state) |
| dec_gray_in | input | 12 | Gray word to decode |
| dec_bin_out | output | 12 | Decoded binary word |

## Verification
The bench builds the block with its default 12-bit sample width. At that width the full-scale and mid-scale codes can be written out by hand, as can the bit-11 and bit-10 Gray boundaries. Because the width is this small, every format code meets those corner samples, and the round trip through the decoder is compared against the original sample. The override register and the strap are then changed at the same edges as samples, to check at the ports that each format switch lands on a clean boundary.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  typedef enum logic [1:0] {
    FMT_OFFSET = 2'b00,
    FMT_TWOS   = 2'b01,
    FMT_GRAY   = 2'b10,
    FMT_RSVD   = 2'b11
  } fmt_e;
endpackage

// File: rtl/sfu_fmt_select.sv
module sfu_fmt_select
  import sfu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] strap_fmt,
  input  logic       cfg_wr,
  input  logic       cfg_override,
  input  logic [1:0] cfg_fmt,
  output fmt_e       eff_fmt
);
  logic       ovr_on_q;
  logic [1:0] ovr_code_q;
  logic [1:0] raw_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_on_q   <= 1'b0;
      ovr_code_q <= 2'b00;
    end else if (cfg_wr) begin
      ovr_on_q   <= cfg_override;
      ovr_code_q <= cfg_fmt;
    end
  end

  assign raw_code = ovr_on_q ? ovr_code_q : strap_fmt;

  always_comb begin
    case (raw_code)
      2'b01:   eff_fmt = FMT_TWOS;
      2'b10:   eff_fmt = FMT_GRAY;
      default: eff_fmt = FMT_OFFSET;
    endcase
  end
endmodule

// File: rtl/sfu_encoder.sv
module sfu_encoder
  import sfu_pkg::*;
#(
  parameter int W = 12
) (
  input  fmt_e         fmt,
  input  logic [W-1:0] bin_in,
  output logic [W-1:0] enc_out
);
  localparam int MSB = W - 1;
  logic [W-1:0] gray;
  logic [W-1:0] twos;

  assign gray[MSB] = bin_in[MSB];
  for (genvar i = 0; i < MSB; i++) begin : g_gray
    assign gray[i] = bin_in[i] ^ bin_in[i+1];
  end

  assign twos = {~bin_in[MSB], bin_in[MSB-1:0]};

  always_comb begin
    case (fmt)
      FMT_TWOS: enc_out = twos;
      FMT_GRAY: enc_out = gray;
      default:  enc_out = bin_in;
    endcase
  end
endmodule

// File: rtl/sfu_gray_decoder.sv
module sfu_gray_decoder #(
  parameter int W = 12
) (
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  localparam int MSB = W - 1;

  assign bin_out[MSB] = gray_in[MSB];
  for (genvar i = MSB - 1; i >= 0; i--) begin : g_chain
    assign bin_out[i] = gray_in[i] ^ bin_out[i+1];
  end
endmodule

// File: rtl/sfu_out_stage.sv
module sfu_out_stage #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] enc_in,
  input  logic         out_en,
  output logic [W-1:0] data_q,
  output logic         valid_q,
  output wire  [W-1:0] dout,
  output wire          dout_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) data_q <= enc_in;
    end
  end

  assign dout       = out_en ? data_q  : {W{1'bz}};
  assign dout_valid = out_en ? valid_q : 1'bz;
endmodule

// File: rtl/sample_format_unit.sv
module sample_format_unit
  import sfu_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_sample,
  input  logic [1:0]   strap_fmt,
  input  logic         cfg_wr,
  input  logic         cfg_override,
  input  logic [1:0]   cfg_fmt,
  input  logic         out_en,
  output wire  [W-1:0] dout,
  output wire          dout_valid,
  input  logic [W-1:0] dec_gray_in,
  output logic [W-1:0] dec_bin_out
);
  fmt_e         eff_fmt;
  logic [W-1:0] enc_word;
  logic [W-1:0] data_q;
  logic         valid_q;

  sfu_fmt_select u_sel (
    .clk(clk), .rst(rst), .strap_fmt(strap_fmt), .cfg_wr(cfg_wr),
    .cfg_override(cfg_override), .cfg_fmt(cfg_fmt), .eff_fmt(eff_fmt)
  );

  sfu_encoder #(.W(W)) u_enc (
    .fmt(eff_fmt), .bin_in(in_sample), .enc_out(enc_word)
  );

  sfu_out_stage #(.W(W)) u_out (
    .clk(clk), .rst(rst), .in_valid(in_valid), .enc_in(enc_word),
    .out_en(out_en), .data_q(data_q), .valid_q(valid_q),
    .dout(dout), .dout_valid(dout_valid)
  );

  sfu_gray_decoder #(.W(W)) u_dec (
    .gray_in(dec_gray_in), .bin_out(dec_bin_out)
  );
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_sample,
  input logic [1:0]   eff_fmt,
  input logic [W-1:0] data_q,
  input logic         valid_q
);
  p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> valid_q);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!valid_q && $stable(data_q)));

  p_offset_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && eff_fmt == 2'b00) |=> data_q == $past(in_sample));

  p_twos_msb_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && eff_fmt == 2'b01) |=>
      data_q == {~$past(in_sample[W-1]), $past(in_sample[W-2:0])});

  p_gray_top_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && eff_fmt == 2'b10) |=> data_q[W-1] == $past(in_sample[W-1]));

  p_no_rsvd_r5: assert property (@(posedge clk) disable iff (rst)
    eff_fmt != 2'b11);
endmodule

bind sample_format_unit sfu_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
  .eff_fmt(eff_fmt), .data_q(data_q), .valid_q(valid_q)
);

// File: tb/sample_format_unit_tb.sv
module sample_format_unit_tb;
  localparam int W = 12;
  localparam int NV = 14;
  // {format code, sample, expected word}
  localparam logic [25:0] VEC [NV] = '{
    {2'b00, 12'h800, 12'h800}, {2'b00, 12'h000, 12'h000},
    {2'b00, 12'hFFF, 12'hFFF}, {2'b01, 12'h800, 12'h000},
    {2'b01, 12'h000, 12'h800}, {2'b01, 12'hFFF, 12'h7FF},
    {2'b01, 12'h7FF, 12'hFFF}, {2'b10, 12'h800, 12'hC00},
    {2'b10, 12'h000, 12'h000}, {2'b10, 12'hFFF, 12'h800},
    {2'b10, 12'h7FF, 12'h400}, {2'b10, 12'h801, 12'hC01},
    {2'b11, 12'h5A5, 12'h5A5}, {2'b11, 12'hFFF, 12'hFFF}
  };

  logic clk = 0, rst = 1, in_valid = 0, cfg_wr = 0, cfg_override = 0, out_en = 1;
  logic [W-1:0] in_sample = '0, dec_gray_in = '0;
  logic [1:0] strap_fmt = 2'b00, cfg_fmt = 2'b00;
  wire  [W-1:0] dout;
  wire  dout_valid;
  logic [W-1:0] dec_bin_out;
  int checks = 0, errors = 0;
  logic [W-1:0] held;

  always #5 clk = ~clk;

  sample_format_unit #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .strap_fmt(strap_fmt), .cfg_wr(cfg_wr), .cfg_override(cfg_override),
    .cfg_fmt(cfg_fmt), .out_en(out_en), .dout(dout), .dout_valid(dout_valid),
    .dec_gray_in(dec_gray_in), .dec_bin_out(dec_bin_out)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // present one sample at the next edge, then sample outputs at the following negedge
  task automatic push(input logic [W-1:0] s);
    in_sample = s; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 data", dout, '0);
    check("R1 valid", {11'b0, dout_valid}, 12'h001 & {11'b0, 1'b0});

    // table walk via strap code: R2 R3 R4 R5 R7
    for (int i = 0; i < NV; i++) begin
      strap_fmt = VEC[i][25:24];
      push(VEC[i][23:12]);
      check("R2/R3/R4/R5 vec", dout, VEC[i][11:0]);
      check("R7 valid", {11'b0, dout_valid}, 12'h001);
    end

    // R11 round trip through the decoder, and R12-style mid-scale already covered
    for (int v = 0; v < 4096; v += 273) begin
      strap_fmt = 2'b10;
      push(W'(v));
      check("R4 gray", dout, to_gray(W'(v)));
      dec_gray_in = dout;
      #1 check("R11 decode", dec_bin_out, W'(v));
    end

    // R9: idle edge holds word, drops valid
    strap_fmt = 2'b00;
    push(12'h3C3);
    held = dout;
    @(negedge clk);
    check("R9 hold", dout, held);
    check("R9 valid low", {11'b0, dout_valid}, 12'h000);

    // R6/R8: override written at same edge as a sample
    strap_fmt = 2'b00;
    cfg_wr = 1; cfg_override = 1; cfg_fmt = 2'b10;
    push(12'h800);
    cfg_wr = 0;
    check("R8 old format at write edge", dout, 12'h800);
    push(12'h800);
    check("R6 override gray", dout, 12'hC00);
    strap_fmt = 2'b01;
    push(12'h800);
    check("R6 strap ignored under override", dout, 12'hC00);
    // reserved code through register: R5
    cfg_wr = 1; cfg_override = 1; cfg_fmt = 2'b11;
    @(negedge clk); cfg_wr = 0;
    push(12'hABC);
    check("R5 reserved register", dout, 12'hABC);
    // release to strap (two's complement)
    cfg_wr = 1; cfg_override = 0; cfg_fmt = 2'b10;
    @(negedge clk); cfg_wr = 0;
    push(12'h800);
    check("R6 release to strap", dout, 12'h000);
    // R8 strap change applies at its own edge
    strap_fmt = 2'b10;
    push(12'h7FF);
    check("R8 strap same edge", dout, 12'h400);

    // R10: outputs released while disabled
    strap_fmt = 2'b00;
    push(12'hFFF);
    out_en = 0;
    #1;
    checks++;
    if (!((dout === {W{1'bz}}) || (dout === '0))) begin
      errors++; $display("FAIL R10 data: actual=%h expected=zzz", dout);
    end
    checks++;
    if (!((dout_valid === 1'bz) || (dout_valid === 1'b0))) begin
      errors++; $display("FAIL R10 valid: actual=%b expected=z", dout_valid);
    end
    out_en = 1;
    #1 check("R10 re-enable shows held word", dout, 12'hFFF);

    // R1/R6: reset clears override and word
    cfg_wr = 1; cfg_override = 1; cfg_fmt = 2'b01;
    @(negedge clk); cfg_wr = 0;
    rst = 1; @(negedge clk); rst = 0;
    check("R1 word after reset", dout, '0);
    strap_fmt = 2'b00;
    push(12'h800);
    check("R6 reset returns to strap", dout, 12'h800);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule